// File: doc/BRIEF.md
# Comparator control and status interface

This block is the register front end for a single analog comparator, sitting on a simple peripheral bus clocked by `pclk`. It holds three words: comparator configuration, comparator status and reference-voltage configuration. Every configuration field is driven straight out to the analog macro. The raw, asynchronous comparator decision comes in on `cmp_raw_i` and passes through a flop chain into the `pclk` domain. Any change of the synchronized level, rising or falling, sets a sticky interrupt flag. Software clears the flag by writing a one to it.

The interrupt line is the flag gated by the interrupt enable. A power-down wake request is the same flag, gated by both the interrupt enable and the wake enable. While the comparator is disabled, the synchronizer chain is held at zero, no change events occur, and the readable level is zero. When the comparator is enabled again and the first sample is high, the rise from zero counts as a change.

A bus-phase state machine tracks each transfer. Its states are `BUS_IDLE` (no select), `BUS_SETUP` (select without enable) and `BUS_ACCESS` (select with enable). Its transitions are:
- IDLE→SETUP when select rises.
- SETUP→ACCESS when enable rises.
- ACCESS→SETUP for a back-to-back transfer.
- ACCESS→IDLE when select drops.
- SETUP→IDLE on an abandoned setup.

A write commits only on the SETUP→ACCESS transition.

Top module: `acmp_regif`

## Requirements
- R1: After reset, all three registers read zero and `irq_o`, `wake_o` and every configuration output are 0.
- R2: Word offset 0x0 holds: comparator enable (bit 0), interrupt enable (bit 1), hysteresis enable (bit 2), negative-input select (bits 5:4) and wake enable (bit 31). Every other bit reads 0. The fields drive `cmp_en_o`, `hys_en_o` and `neg_sel_o`.
- R3: `neg_sel_o` carries the written 2-bit value unchanged: 00 external pin, 01 programmable reference, 10 fixed reference, 11 analog ground.
- R4: Offset 0x8 holds: reference level (bits 3:0), reference enable (bit 4) and source select (bit 5, 0 = analog supply, 1 = system reference). Other bits read 0. The fields drive `vref_lvl_o`, `vref_en_o` and `vref_src_o`.
- R5: Status bit 1 at offset 0x4 is the synchronized comparator level. It follows a change of `cmp_raw_i` after two `pclk` edges, reads 0 while the comparator is disabled, and ignores bus writes.
- R6: Status bit 0, the flag, becomes 1 on the third `pclk` edge after `cmp_raw_i` changes, for both rising and falling changes.
- R7: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged.
- R8: When a change event and a clearing write land on the same edge, the flag ends up 1.
- R9: `irq_o` is 1 exactly when the flag and the interrupt enable are both 1.
- R10: `wake_o` is 1 exactly when the flag, the interrupt enable and the wake enable are all 1.
- R11: While disabled, changes of `cmp_raw_i` never set the flag. Enabling while `cmp_raw_i` is 1 sets it.
- R12: Offset 0xC reads zero and writes to it change nothing.
- R13: A write commits only when an access phase follows a setup phase. A setup phase that is abandoned writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and sampling clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed word |
| cmp_raw_i | input | 1 | Asynchronous comparator decision |
| cmp_en_o | output | 1 | Comparator enable to analog |
| hys_en_o | output | 1 | Hysteresis enable to analog |
| neg_sel_o | output | 2 | Negative-input select to analog |
| vref_lvl_o | output | 4 | Reference level setting |
| vref_en_o | output | 1 | Reference enable |
| vref_src_o | output | 1 | Reference source select |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Power-down wake request |

## Verification
The embedded assertions check several relations on every cycle:
- A write strobe always lands in the access state.
- A disabled comparator produces no change event.
- A clear without a concurrent event leaves the flag low, and a concurrent event keeps it high.
- The flag rises only after an event.
- The wake request implies the interrupt.
- Reserved bits read zero.

Only the bench scenarios show the rest:
- The exact two- and three-edge latencies.
- The field positions and encodings.
- The ignored writes to the status level and to the unmapped word.
- The first-sample behaviour on re-enable.
- The outcome of a clear colliding with a change.

// File: rtl/acmp_regif_pkg.sv
package acmp_regif_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic       wake_en;
        logic [1:0] neg_sel;
        logic       hys_en;
        logic       irq_en;
        logic       cmp_en;
    } cmp_cfg_t;

    typedef struct packed {
        logic       src_sel;
        logic       lvl_en;
        logic [3:0] lvl;
    } vref_cfg_t;

    localparam int unsigned WORD_CFG  = 0;
    localparam int unsigned WORD_STAT = 1;
    localparam int unsigned WORD_VREF = 2;

endpackage

// File: rtl/acmp_bus_fsm.sv
module acmp_bus_fsm
    import acmp_regif_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              wr_cfg,
    output logic              wr_stat,
    output logic              wr_vref,
    output logic [ADDR_W-3:0] word_idx
);
    localparam int WORD_W = ADDR_W - 2;

    bus_state_e state_q, state_d;
    logic       wr_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   state_d = psel ? BUS_SETUP : BUS_IDLE;
            BUS_SETUP:  begin
                if (!psel)        state_d = BUS_IDLE;
                else if (penable) state_d = BUS_ACCESS;
                else              state_d = BUS_SETUP;
            end
            BUS_ACCESS: begin
                if (psel && !penable) state_d = BUS_SETUP;
                else                  state_d = BUS_IDLE;
            end
            default:    state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        word_idx = paddr[ADDR_W-1:2];
        wr_stb   = (state_q == BUS_SETUP) && psel && penable && pwrite;
        wr_cfg   = wr_stb && (word_idx == WORD_W'(WORD_CFG));
        wr_stat  = wr_stb && (word_idx == WORD_W'(WORD_STAT));
        wr_vref  = wr_stb && (word_idx == WORD_W'(WORD_VREF));
    end

    // R13
    wr_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (state_q == BUS_ACCESS));

endmodule

// File: rtl/acmp_sync_edge.sv
module acmp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic level,
    output logic chg
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)   chain_q[0] <= 1'b0;
                    else if (!en) chain_q[0] <= 1'b0;
                    else          chain_q[0] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)   chain_q[i] <= 1'b0;
                    else if (!en) chain_q[i] <= 1'b0;
                    else          chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   prev_q <= 1'b0;
        else if (!en) prev_q <= 1'b0;
        else          prev_q <= chain_q[STAGES-1];
    end

    assign level = en & chain_q[STAGES-1];
    assign chg   = en & (chain_q[STAGES-1] ^ prev_q);

    // R11
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> !chg);

    // R5
    level_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !level);

endmodule

// File: rtl/acmp_flag.sv
module acmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end

    // R7
    clr_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/acmp_regif.sv
module acmp_regif
    import acmp_regif_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int SYNC_STG  = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              cmp_raw_i,
    output logic              cmp_en_o,
    output logic              hys_en_o,
    output logic [1:0]        neg_sel_o,
    output logic [3:0]        vref_lvl_o,
    output logic              vref_en_o,
    output logic              vref_src_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int TOP_B  = DATA_W - 1;

    cmp_cfg_t          cfg_q;
    vref_cfg_t         vref_q;
    logic              wr_cfg, wr_stat, wr_vref;
    logic [WORD_W-1:0] word_idx;
    logic              sync_lvl, chg_evt, flag;
    logic              unused_bits;

    acmp_bus_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk      (pclk),
        .rst_n    (presetn),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .wr_cfg   (wr_cfg),
        .wr_stat  (wr_stat),
        .wr_vref  (wr_vref),
        .word_idx (word_idx)
    );

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            cfg_q  <= '0;
            vref_q <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_q.cmp_en  <= pwdata[0];
                cfg_q.irq_en  <= pwdata[1];
                cfg_q.hys_en  <= pwdata[2];
                cfg_q.neg_sel <= pwdata[5:4];
                cfg_q.wake_en <= pwdata[TOP_B];
            end
            if (wr_vref) begin
                vref_q <= pwdata[5:0];
            end
        end
    end

    acmp_sync_edge #(.STAGES(SYNC_STG)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .en    (cfg_q.cmp_en),
        .raw   (cmp_raw_i),
        .level (sync_lvl),
        .chg   (chg_evt)
    );

    acmp_flag u_flag (
        .clk    (pclk),
        .rst_n  (presetn),
        .set_i  (chg_evt),
        .clr_i  (wr_stat && pwdata[0]),
        .flag_o (flag)
    );

    always_comb begin
        prdata = '0;
        unique case (word_idx)
            WORD_W'(WORD_CFG): begin
                prdata[0]     = cfg_q.cmp_en;
                prdata[1]     = cfg_q.irq_en;
                prdata[2]     = cfg_q.hys_en;
                prdata[5:4]   = cfg_q.neg_sel;
                prdata[TOP_B] = cfg_q.wake_en;
            end
            WORD_W'(WORD_STAT): begin
                prdata[0] = flag;
                prdata[1] = sync_lvl;
            end
            WORD_W'(WORD_VREF): prdata[5:0] = vref_q;
            default:            prdata = '0;
        endcase
    end

    assign cmp_en_o   = cfg_q.cmp_en;
    assign hys_en_o   = cfg_q.hys_en;
    assign neg_sel_o  = cfg_q.neg_sel;
    assign vref_lvl_o = vref_q.lvl;
    assign vref_en_o  = vref_q.lvl_en;
    assign vref_src_o = vref_q.src_sel;
    assign irq_o      = flag & cfg_q.irq_en;
    assign wake_o     = irq_o & cfg_q.wake_en;
    assign unused_bits = ^{pwdata[TOP_B-1:6], pwdata[3], paddr[1:0]};

    // R6
    flag_rise_chk: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(flag) |-> $past(chg_evt));

    // R10
    wake_implies_irq_chk: assert property (@(posedge pclk) disable iff (!presetn)
        wake_o |-> irq_o);

    // R2
    cfg_reserved_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (word_idx == WORD_W'(WORD_CFG)) |-> (prdata[TOP_B-1:6] == '0 && !prdata[3]));

    // R12
    hole_reads_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (word_idx == WORD_W'(3)) |-> (prdata == '0));

endmodule

// File: tb/acmp_regif_tb.sv
module acmp_regif_tb;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        cmp_raw_i = 1'b0;
    logic        cmp_en_o, hys_en_o, vref_en_o, vref_src_o, irq_o, wake_o;
    logic [1:0]  neg_sel_o;
    logic [3:0]  vref_lvl_o;

    int n_chk = 0;
    int n_err = 0;

    // bench model
    logic [31:0] m_cfg = '0;
    logic [31:0] m_vref = '0;
    logic        m_flag = 1'b0;
    logic        m_sync = 1'b0;

    always #5 pclk = ~pclk;

    acmp_regif u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .cmp_raw_i(cmp_raw_i), .cmp_en_o(cmp_en_o), .hys_en_o(hys_en_o),
        .neg_sel_o(neg_sel_o), .vref_lvl_o(vref_lvl_o), .vref_en_o(vref_en_o),
        .vref_src_o(vref_src_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [31:0] cfg_mask(input logic [31:0] d);
        return d & 32'h8000_0037;
    endfunction

    function automatic logic [31:0] exp_stat();
        return {30'b0, m_sync, m_flag};
    endfunction

    function automatic logic exp_irq();
        return m_flag & m_cfg[1];
    endfunction

    function automatic logic exp_wake();
        return m_flag & m_cfg[1] & m_cfg[31];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1; #1 d = prdata;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    // settle after any change, then update the model for a change event
    task automatic settle();
        logic ns;
        idle(5);
        ns = m_cfg[0] ? cmp_raw_i : 1'b0;
        if (m_cfg[0] && ns != m_sync) m_flag = 1'b1;
        m_sync = ns;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] r;
        bus_rd(4'h4, r); chk({tag, " status"}, r, exp_stat());
        bus_rd(4'h0, r); chk({tag, " cfg"}, r, m_cfg);
        bus_rd(4'h8, r); chk({tag, " vref"}, r, m_vref);
        chk({tag, " irq R9"}, {31'b0, irq_o}, {31'b0, exp_irq()});
        chk({tag, " wake R10"}, {31'b0, wake_o}, {31'b0, exp_wake()});
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        idle(3);
        presetn = 1'b1;
        idle(1);

        // R1 reset state
        bus_rd(4'h0, r); chk("R1 cfg", r, 32'h0);
        bus_rd(4'h4, r); chk("R1 stat", r, 32'h0);
        bus_rd(4'h8, r); chk("R1 vref", r, 32'h0);
        chk("R1 outs", {24'b0, cmp_en_o, hys_en_o, neg_sel_o, irq_o, wake_o, vref_en_o, vref_src_o}, 32'h0);

        // R2 field positions, reserved bits zero
        bus_wr(4'h0, 32'hFFFF_FFFE); m_cfg = cfg_mask(32'hFFFF_FFFE);
        bus_rd(4'h0, r); chk("R2 readback", r, 32'h8000_0036);
        chk("R2 hys out", {31'b0, hys_en_o}, 32'h1);
        chk("R2 en out", {31'b0, cmp_en_o}, 32'h0);

        // R3 encodings
        for (int k = 0; k < 4; k++) begin
            bus_wr(4'h0, 32'(k) << 4); m_cfg = cfg_mask(32'(k) << 4);
            chk("R3 neg_sel", {30'b0, neg_sel_o}, 32'(k));
        end

        // R4 reference word
        bus_wr(4'h8, 32'hFFFF_FFE5); m_vref = 32'h25;
        bus_rd(4'h8, r); chk("R4 readback", r, 32'h25);
        chk("R4 outs", {26'b0, vref_src_o, vref_en_o, vref_lvl_o}, 32'h25);

        // R12 hole
        bus_wr(4'hC, 32'hFFFF_FFFF);
        bus_rd(4'hC, r); chk("R12 hole read", r, 32'h0);
        check_all("R12");

        // R6 latency and R9: enable with ie, raw low
        bus_wr(4'h0, 32'h3); m_cfg = 32'h3; settle();
        @(negedge pclk); cmp_raw_i = 1'b1;
        @(posedge pclk); @(posedge pclk); @(negedge pclk);
        chk("R6 not yet at edge2", {31'b0, irq_o}, 32'h0);
        @(negedge pclk);
        chk("R6 rising flag at edge3", {31'b0, irq_o}, 32'h1);
        settle();
        bus_rd(4'h4, r); chk("R5 level high", r, 32'h3);

        // R7 write 0 no effect, write 1 clears
        bus_wr(4'h4, 32'h0);
        bus_rd(4'h4, r); chk("R7 write0 kept", r, 32'h3);
        bus_wr(4'h4, 32'h1); m_flag = 0;
        bus_rd(4'h4, r); chk("R7 w1c", r, 32'h2);

        // R5 level write ignored
        bus_wr(4'h4, 32'h2);
        cmp_raw_i = 1'b0; settle();
        bus_rd(4'h4, r); chk("R6 falling sets flag", r, 32'h1);
        bus_wr(4'h4, 32'h3); m_flag = 0;
        bus_rd(4'h4, r); chk("R5 level write ignored", r, 32'h0);

        // R10 wake gating
        bus_wr(4'h0, 32'h8000_0003); m_cfg = 32'h8000_0003;
        cmp_raw_i = 1'b1; settle();
        chk("R10 wake on", {31'b0, wake_o}, 32'h1);
        bus_wr(4'h0, 32'h8000_0001); m_cfg = 32'h8000_0001;
        chk("R10 wake off w/o ie", {31'b0, wake_o}, 32'h0);

        // R8 collision: change event and clear on same edge, flag was 1
        bus_wr(4'h0, 32'h3); m_cfg = 32'h3;
        @(negedge pclk); cmp_raw_i = 1'b0;
        bus_wr(4'h4, 32'h1);
        idle(4); m_sync = 1'b0;
        bus_rd(4'h4, r); chk("R8 set wins", r, 32'h1);
        bus_wr(4'h4, 32'h1); m_flag = 0;

        // R11 disabled: no flag; re-enable with raw high sets flag
        bus_wr(4'h0, 32'h2); m_cfg = 32'h2; settle();
        bus_wr(4'h4, 32'h1); m_flag = 0;
        cmp_raw_i = 1'b1; settle();
        cmp_raw_i = 1'b0; settle();
        cmp_raw_i = 1'b1; settle();
        bus_rd(4'h4, r); chk("R11 quiet off", r, 32'h0);
        bus_wr(4'h0, 32'h3); m_cfg = 32'h3; settle();
        bus_rd(4'h4, r); chk("R11 first sample", r, 32'h3);

        // R13 abandoned setup writes nothing
        @(negedge pclk); psel = 1; pwrite = 1; paddr = 4'h8; pwdata = 32'h1F;
        @(negedge pclk); psel = 0; pwrite = 0;
        bus_rd(4'h8, r); chk("R13 abandoned setup", r, m_vref);

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom_range(0, 3));
            d  = $urandom;
            case (op)
                0: begin bus_wr(4'h0, d); m_cfg = cfg_mask(d); end
                1: begin bus_wr(4'h8, d); m_vref = d & 32'h3F; end
                2: begin bus_wr(4'h4, d); if (d[0]) m_flag = 0; end
                default: cmp_raw_i = ~cmp_raw_i;
            endcase
            settle();
            check_all("RND R2 R4 R5 R6 R7");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule